// File: doc/BRIEF.md
# Registered 8x8 Multiplier with Round Control

This block multiplies two 8-bit operands, each held in its own input register, and keeps the 16-bit result in a product register. The X register, the Y register and the product register each have a separate load strobe on one shared clock. The product register captures the result of the current X, Y and round registers. A build-time parameter picks two's-complement fractional operands or unsigned-magnitude operands.

The product comes out as an upper byte and a lower byte. Each byte has an active-low output enable. The enable is combinational, and when it is high the byte is flagged as not driven and reads as zero.

A registered round bit adds a one at the position just below the least significant bit of the upper byte, so the upper byte alone can serve as a rounded 8-bit product. Rounding always moves toward plus infinity.

In signed mode the fractional result goes into the 16 output bits as follows: the sign, seven high magnitude bits, the sign again, then seven low magnitude bits. The unrepresentable case of -1 times -1 wraps to -1.

Top module: `regmul8`

## Requirements
- R1: A synchronous active-high reset clears the X, Y, round and product registers to zero. With both enables low, both bytes then read 0x00.
- R2: The X register changes only in a cycle with `ld_x` high, and the Y register changes only in a cycle with `ld_y` high. Operand pins that change without their strobe do not affect a later product.
- R3: The product register loads only in a cycle with `ld_p` high. It takes the value formed from the X, Y and round registers as they stood before that edge. Without `ld_p` both bytes hold.
- R4: With `SIGNED_MODE`=1, let f be the 16-bit two's-complement value X*Y + 64*round. Then `hi_byte` = {f[14], f[13:7]} and `lo_byte` = {f[14], f[6:0]}, so bit 7 of both bytes is the product sign.
- R5: With `SIGNED_MODE`=1, 0x80 times 0x80 gives `hi_byte`=0x80 and `lo_byte`=0x80, which is -1 and not +1.
- R6: With `SIGNED_MODE`=1 and the round register set, one is added at product bit 6, the top bit of the low byte's magnitude. The addition always goes upward, for negative products too.
- R7: With `SIGNED_MODE`=0, {`hi_byte`,`lo_byte`} = X*Y + 128*round as unsigned 16-bit values.
- R8: With `SIGNED_MODE`=1 the round register loads `rnd_in` when either `ld_x` or `ld_y` is high. With `SIGNED_MODE`=0 it loads only when `ld_x` is high.
- R9: When `oe_hi_n` (or `oe_lo_n`) is high, `hi_valid` (`lo_valid`) is low and the byte reads 0x00. The enables are not registered and act in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_x | input | 1 | Load strobe for X register |
| ld_y | input | 1 | Load strobe for Y register |
| ld_p | input | 1 | Load strobe for product register |
| x_in | input | 8 | X operand |
| y_in | input | 8 | Y operand |
| rnd_in | input | 1 | Round request |
| oe_hi_n | input | 1 | Active-low enable, upper byte |
| oe_lo_n | input | 1 | Active-low enable, lower byte |
| hi_byte | output | 8 | Upper product byte |
| lo_byte | output | 8 | Lower product byte |
| hi_valid | output | 1 | Upper byte driven |
| lo_valid | output | 1 | Lower byte driven |

## Verification
Two functions can fall in the same cycle: an operand load (with its round capture) and a product load. The bench raises `ld_x`, `ld_y` and `ld_p` on one edge with new operands. It expects the product to reflect the operands and round bit held before that edge, and the new ones to appear only after a further `ld_p`. A second instance built in unsigned mode gets the same stimulus, which shows that a round request on `ld_y` alone is taken in signed mode and ignored in unsigned mode.

// File: rtl/regmul8.sv
module regmul8 #(
  parameter bit SIGNED_MODE = 1'b1,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_x,
  input  logic         ld_y,
  input  logic         ld_p,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         rnd_in,
  input  logic         oe_hi_n,
  input  logic         oe_lo_n,
  output logic [W-1:0] hi_byte,
  output logic [W-1:0] lo_byte,
  output logic         hi_valid,
  output logic         lo_valid
);
  localparam int PW = 2 * W;
  localparam int RPOS = SIGNED_MODE ? W - 2 : W - 1;

  logic [W-1:0]  x_q, y_q;
  logic          r_q;
  logic [PW-1:0] p_q;
  logic [PW-1:0] prod, rounded, packed_p;
  logic          r_ld;

  generate
    if (SIGNED_MODE) begin : g_sgn
      assign r_ld = ld_x | ld_y;
      assign prod = PW'($signed({{W{x_q[W-1]}}, x_q}) * $signed({{W{y_q[W-1]}}, y_q}));
      assign rounded = prod + (PW'(r_q) << RPOS);
      assign packed_p = {rounded[PW-2], rounded[PW-3:W-1], rounded[PW-2], rounded[W-2:0]};
    end else begin : g_uns
      assign r_ld = ld_x;
      assign prod = PW'(x_q) * PW'(y_q);
      assign rounded = prod + (PW'(r_q) << RPOS);
      assign packed_p = rounded;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
      r_q <= 1'b0;
      p_q <= '0;
    end else begin
      if (ld_x) x_q <= x_in;
      if (ld_y) y_q <= y_in;
      if (r_ld) r_q <= rnd_in;
      if (ld_p) p_q <= packed_p;
    end
  end

  assign hi_valid = ~oe_hi_n;
  assign lo_valid = ~oe_lo_n;
  assign hi_byte  = oe_hi_n ? '0 : p_q[PW-1:W];
  assign lo_byte  = oe_lo_n ? '0 : p_q[W-1:0];
endmodule

// File: rtl/regmul8_chk.sv
module regmul8_chk #(
  parameter bit SIGNED_MODE = 1'b1,
  parameter int W = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ld_x,
  input logic          ld_y,
  input logic          ld_p,
  input logic          rnd_in,
  input logic [W-1:0]  x_in,
  input logic [W-1:0]  x_q,
  input logic [W-1:0]  y_q,
  input logic          r_q,
  input logic [2*W-1:0] p_q,
  input logic          oe_hi_n,
  input logic          oe_lo_n,
  input logic          hi_valid,
  input logic          lo_valid,
  input logic [W-1:0]  hi_byte,
  input logic [W-1:0]  lo_byte
);
  logic any_strobe;
  assign any_strobe = SIGNED_MODE ? (ld_x | ld_y) : ld_x;

  AST_X_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_x |=> $stable(x_q)); // R2
  AST_X_TAKE: assert property (@(posedge clk) disable iff (rst) ld_x |=> x_q == $past(x_in)); // R2
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_y |=> $stable(y_q)); // R2
  AST_P_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_p |=> $stable(p_q)); // R3
  AST_RND_CAPTURE: assert property (@(posedge clk) disable iff (rst) any_strobe |=> r_q == $past(rnd_in)); // R8
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (rst) !any_strobe |=> $stable(r_q)); // R8
  AST_MINUS_ONE: assert property (@(posedge clk) disable iff (rst)
    (SIGNED_MODE && ld_p && x_q == {1'b1, {(W-1){1'b0}}} && y_q == {1'b1, {(W-1){1'b0}}} && !r_q)
    |=> p_q == {1'b1, {(W-1){1'b0}}, 1'b1, {(W-1){1'b0}}}); // R5
  AST_SIGN_COPY: assert property (@(posedge clk) disable iff (rst) SIGNED_MODE |-> p_q[2*W-1] == p_q[W-1]); // R4
  AST_HI_OFF: assert property (@(posedge clk) disable iff (rst) oe_hi_n |-> (!hi_valid && hi_byte == '0)); // R9
  AST_LO_OFF: assert property (@(posedge clk) disable iff (rst) oe_lo_n |-> (!lo_valid && lo_byte == '0)); // R9
  AST_CLEARED: assert property (@(posedge clk) rst |=> (p_q == '0 && r_q == 1'b0)); // R1
endmodule

bind regmul8 regmul8_chk #(.SIGNED_MODE(SIGNED_MODE), .W(W)) u_chk (.*);

// File: tb/regmul8_test.sv
module regmul8_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, ld_x, ld_y, ld_p, rnd_in, oe_hi_n, oe_lo_n;
  logic [7:0] x_in, y_in;
  logic [7:0] hi_s, lo_s, hi_u, lo_u;
  logic hv_s, lv_s, hv_u, lv_u;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  regmul8 #(.SIGNED_MODE(1'b1)) uut (
    .clk(clk), .rst(rst), .ld_x(ld_x), .ld_y(ld_y), .ld_p(ld_p),
    .x_in(x_in), .y_in(y_in), .rnd_in(rnd_in), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
    .hi_byte(hi_s), .lo_byte(lo_s), .hi_valid(hv_s), .lo_valid(lv_s));

  regmul8 #(.SIGNED_MODE(1'b0)) uut_u (
    .clk(clk), .rst(rst), .ld_x(ld_x), .ld_y(ld_y), .ld_p(ld_p),
    .x_in(x_in), .y_in(y_in), .rnd_in(rnd_in), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
    .hi_byte(hi_u), .lo_byte(lo_u), .hi_valid(hv_u), .lo_valid(lv_u));

  localparam int NV = 10;
  localparam logic [7:0]  VX [NV] = '{8'h00, 8'h00, 8'h80, 8'h80, 8'hFF, 8'hFF, 8'h40, 8'h7F, 8'h80, 8'hFE};
  localparam logic [7:0]  VY [NV] = '{8'h00, 8'h55, 8'h80, 8'h80, 8'hFF, 8'hFF, 8'h40, 8'h7F, 8'h7F, 8'h03};
  localparam logic        VR [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [15:0] VE [NV] = '{16'h0000, 16'h0040, 16'h8080, 16'h80C0, 16'h0001,
                                      16'h0041, 16'h2000, 16'h7E01, 16'h8180, 16'h003A};

  function automatic logic [15:0] ref_u(logic [7:0] a, logic [7:0] b, logic r);
    return 16'(a * b) + (r ? 16'd128 : 16'd0);
  endfunction

  function automatic logic [15:0] ref_s(logic [7:0] a, logic [7:0] b, logic r);
    int v;
    logic [15:0] f;
    v = $signed(a) * $signed(b) + (r ? 64 : 0);
    f = 16'(v);
    return {f[14], f[13:7], f[14], f[6:0]};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic lx, logic ly, logic lp, logic [7:0] a, logic [7:0] b, logic r);
    @(negedge clk);
    ld_x = lx; ld_y = ly; ld_p = lp; x_in = a; y_in = b; rnd_in = r;
    @(posedge clk);
    #1;
    ld_x = 0; ld_y = 0; ld_p = 0;
  endtask

  task automatic load_and_run(logic [7:0] a, logic [7:0] b, logic r);
    step(1, 1, 0, a, b, r);
    step(0, 0, 1, a, b, r);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; ld_x = 0; ld_y = 0; ld_p = 0; rnd_in = 0; x_in = 0; y_in = 0;
    oe_hi_n = 0; oe_lo_n = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1 signed", {hi_s, lo_s}, 16'h0000);
    chk("R1 unsigned", {hi_u, lo_u}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      load_and_run(VX[i], VY[i], VR[i]);
      chk(VR[i] ? "R4/R5/R6 table" : "R4/R5 table", {hi_s, lo_s}, VE[i]);
      chk("R7 table", {hi_u, lo_u}, ref_u(VX[i], VY[i], VR[i]));
    end

    load_and_run(8'h80, 8'h80, 1'b0);
    chk("R5 minus one", {hi_s, lo_s}, 16'h8080);

    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b;
      logic r;
      a = 8'($urandom); b = 8'($urandom); r = 1'($urandom);
      load_and_run(a, b, r);
      chk("R4/R6 random", {hi_s, lo_s}, ref_s(a, b, r));
      chk("R7 random", {hi_u, lo_u}, ref_u(a, b, r));
    end

    load_and_run(8'h05, 8'h07, 1'b0);
    step(0, 0, 1, 8'h09, 8'h07, 1'b0);
    chk("R2 x pin without strobe", {hi_s, lo_s}, ref_s(8'h05, 8'h07, 1'b0));
    step(1, 0, 0, 8'h09, 8'h07, 1'b0);
    chk("R3 hold without ld_p", {hi_u, lo_u}, ref_u(8'h05, 8'h07, 1'b0));
    step(1, 1, 1, 8'h11, 8'h13, 1'b1);
    chk("R3 same-edge load signed", {hi_s, lo_s}, ref_s(8'h09, 8'h07, 1'b0));
    chk("R3 same-edge load unsigned", {hi_u, lo_u}, ref_u(8'h09, 8'h07, 1'b0));
    step(0, 0, 1, 8'h00, 8'h00, 1'b0);
    chk("R3 next product signed", {hi_s, lo_s}, ref_s(8'h11, 8'h13, 1'b1));
    chk("R3 next product unsigned", {hi_u, lo_u}, ref_u(8'h11, 8'h13, 1'b1));

    load_and_run(8'h00, 8'h00, 1'b0);
    step(0, 1, 0, 8'h00, 8'h00, 1'b1);
    step(0, 0, 1, 8'h00, 8'h00, 1'b0);
    chk("R8 signed round via y strobe", {hi_s, lo_s}, 16'h0040);
    chk("R8 unsigned round ignores y strobe", {hi_u, lo_u}, 16'h0000);
    step(1, 0, 0, 8'h00, 8'h00, 1'b1);
    step(0, 0, 1, 8'h00, 8'h00, 1'b0);
    chk("R8 unsigned round via x strobe", {hi_u, lo_u}, 16'h0080);

    load_and_run(8'hFE, 8'h03, 1'b1);
    chk("R6 negative rounds upward", {hi_s, lo_s}, 16'h003A);

    load_and_run(8'h7F, 8'h7F, 1'b0);
    @(negedge clk);
    oe_hi_n = 1;
    #0.5;
    chk("R9 hi disabled", {7'd0, hv_s, hi_s}, 16'h0000);
    chk("R9 lo still driven", {7'd0, lv_s, lo_s}, 16'h0101);
    oe_hi_n = 0; oe_lo_n = 1;
    #0.5;
    chk("R9 lo disabled", {7'd0, lv_u, lo_u}, 16'h0000);
    chk("R9 hi re-enabled", {7'd0, hv_s, hi_s}, 16'h017E);
    oe_lo_n = 0;

    @(negedge clk);
    rst = 1;
    @(posedge clk);
    #1 rst = 0;
    chk("R1 reset after use", {hi_s, lo_s}, 16'h0000);
    step(0, 0, 1, 8'h00, 8'h00, 1'b0);
    chk("R1 round register cleared", {hi_u, lo_u}, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule